// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a two-port 8K x 16 memory and watches the access cycles of both ports. It turns the two highest word addresses into cross-port doorbells. A write by one port to the other port's mailbox word raises an active-low interrupt towards that other port. The interrupt stays raised until the receiving port reads its own mailbox word. The 16-bit message in each mailbox word is kept in the memory array itself. This block only tracks the two interrupt flags.

Port A receives at address 0x1FFE and port B receives at address 0x1FFF. A single enable input turns the feature off. While it is low, both flags are held clear and the two top words act as plain memory. Every port input is sampled on the rising clock edge. The interrupt outputs are registered, so they change in the cycle after the access that causes the change.

Top module: `mbox_irq_top`

## Requirements
- R1: While rstN is low, aIrqN and bIrqN are both high (deasserted).
- R2: With irqEnable high, a port B write (bCeN=0 and bWeN=0) to address 0x1FFE drives aIrqN low from the next clock edge.
- R3: With irqEnable high, a port A access with aCeN=0 and aOeN=0 at address 0x1FFE returns aIrqN high from the next edge, whatever the value of aWeN.
- R4: With irqEnable high, a port A write (aCeN=0 and aWeN=0) to address 0x1FFF drives bIrqN low from the next clock edge.
- R5: With irqEnable high, a port B access with bCeN=0 and bOeN=0 at address 0x1FFF returns bIrqN high from the next edge, whatever the value of bWeN.
- R6: When a set and a clear of the same interrupt occur in the same cycle, the interrupt ends up asserted (low).
- R7: A port writing to its own mailbox word with its output enable high does not change its own interrupt output.
- R8: Accesses to any address other than the two mailbox words, and any cycle in which a port's chip enable is high, do not change either interrupt output.
- R9: When irqEnable is low, both interrupt outputs are high from the next edge, and mailbox accesses made while it is low raise no interrupt.
- R10: An asserted interrupt stays low across any number of cycles until its clear (R3/R5) or R9 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; port inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqEnable | input | 1 | High enables the mailbox interrupts; low clears and blocks them |
| aCeN | input | 1 | Port A chip enable, active low |
| aOeN | input | 1 | Port A output enable, active low |
| aWeN | input | 1 | Port A write strobe, active low |
| aAddr | input | 13 | Port A word address |
| bCeN | input | 1 | Port B chip enable, active low |
| bOeN | input | 1 | Port B output enable, active low |
| bWeN | input | 1 | Port B write strobe, active low |
| bAddr | input | 13 | Port B word address |
| aIrqN | output | 1 | Interrupt to port A, active low |
| bIrqN | output | 1 | Interrupt to port B, active low |

## Verification
The only state in the block is one flag per port, and each flag drives its port's interrupt pin directly. A wrong flag therefore appears on that pin in the cycle after the faulty edge. Because a flag holds its value until a set or clear arrives, the error also persists at the pin instead of passing by in a single cycle. The bench runs a behavioural model alongside the design and compares both pins every cycle. Mailbox addresses are chosen heavily during that run, so that a wrong decode, a wrong priority or a port swap shows up within a few cycles of the access that exposes it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // number of ports that share the memory; index 0 is port A, 1 is port B
  localparam int MBOX_PORTS = 2;

  // strobes handed from the decoder to the flag registers
  typedef struct packed {
    logic [MBOX_PORTS-1:0] set;    // raise the flag of port i
    logic [MBOX_PORTS-1:0] clr;    // acknowledge by port i
    logic                  flush;  // feature disabled: drop all flags
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                                 irqEnable,
  input  logic [MBOX_PORTS-1:0]                ceN,
  input  logic [MBOX_PORTS-1:0]                oeN,
  input  logic [MBOX_PORTS-1:0]                weN,
  input  logic [MBOX_PORTS-1:0][ADDR_W-1:0]    addr,
  output mboxStrobes_t                         strobes
);
  // highest word address; mailbox of port i sits at TOP_ADDR-(MBOX_PORTS-1)+i
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic [MBOX_PORTS-1:0] setVec;
  logic [MBOX_PORTS-1:0] clrVec;

  for (genvar i = 0; i < MBOX_PORTS; i++) begin : g_port
    localparam int PEER = MBOX_PORTS - 1 - i;
    localparam logic [ADDR_W-1:0] BOX_ADDR =
      TOP_ADDR - ADDR_W'(MBOX_PORTS - 1 - i);

    logic peerWrite;
    logic ownRead;

    // the opposite port writes into this port's mailbox
    assign peerWrite = !ceN[PEER] && !weN[PEER] && (addr[PEER] == BOX_ADDR);
    // this port reads its own mailbox; the write strobe is ignored here
    assign ownRead   = !ceN[i] && !oeN[i] && (addr[i] == BOX_ADDR);

    assign setVec[i] = irqEnable && peerWrite;
    assign clrVec[i] = irqEnable && ownRead;
  end

  assign strobes = '{set: setVec, clr: clrVec, flush: !irqEnable};
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  mboxStrobes_t          strobes,
  output logic [MBOX_PORTS-1:0] irqN
);
  logic [MBOX_PORTS-1:0] pending;

  for (genvar i = 0; i < MBOX_PORTS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pending[i] <= 1'b0;
      else if (strobes.flush)    pending[i] <= 1'b0;
      else if (strobes.set[i])   pending[i] <= 1'b1;  // set beats clear
      else if (strobes.clr[i])   pending[i] <= 1'b0;
    end

    assign irqN[i] = ~pending[i];

    // R2 R4 R6
    set_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.set[i] && !strobes.flush) |=> !irqN[i]);

    // R3 R5
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[i] && !strobes.set[i] && !strobes.flush) |=> irqN[i]);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.set[i] && !strobes.clr[i] && !strobes.flush) |=> $stable(irqN[i]));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.flush |=> irqN[i]);
  end
endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqEnable,
  input  logic              aCeN,
  input  logic              aOeN,
  input  logic              aWeN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              bCeN,
  input  logic              bOeN,
  input  logic              bWeN,
  input  logic [ADDR_W-1:0] bAddr,
  output logic              aIrqN,
  output logic              bIrqN
);
  mboxStrobes_t                     strobes;
  logic [MBOX_PORTS-1:0]            irqVec;
  logic [MBOX_PORTS-1:0][ADDR_W-1:0] addrVec;

  assign addrVec = {bAddr, aAddr};

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .irqEnable (irqEnable),
    .ceN       ({bCeN, aCeN}),
    .oeN       ({bOeN, aOeN}),
    .weN       ({bWeN, aWeN}),
    .addr      (addrVec),
    .strobes   (strobes)
  );

  mbox_flags u_flags (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .irqN    (irqVec)
  );

  assign aIrqN = irqVec[0];
  assign bIrqN = irqVec[1];

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |-> (aIrqN && bIrqN));

  // R8
  no_access_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && aCeN && bCeN) |=> ($stable(aIrqN) && $stable(bIrqN)));
endmodule

// File: tb/mbox_irq_top_test.sv
module mbox_irq_top_test;
  localparam logic [12:0] BOX_A = 13'h1FFE;
  localparam logic [12:0] BOX_B = 13'h1FFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqEnable = 1'b1;
  logic aCeN = 1'b1, aOeN = 1'b1, aWeN = 1'b1;
  logic bCeN = 1'b1, bOeN = 1'b1, bWeN = 1'b1;
  logic [12:0] aAddr = '0, bAddr = '0;
  logic aIrqN, bIrqN;

  int total = 0;
  int bad = 0;
  int refA = 0;  // 1 = interrupt to port A pending
  int refB = 0;

  always #4 clk = ~clk;  // 125 MHz

  mbox_irq_top uut (
    .clk(clk), .rstN(rstN), .irqEnable(irqEnable),
    .aCeN(aCeN), .aOeN(aOeN), .aWeN(aWeN), .aAddr(aAddr),
    .bCeN(bCeN), .bOeN(bOeN), .bWeN(bWeN), .bAddr(bAddr),
    .aIrqN(aIrqN), .bIrqN(bIrqN)
  );

  // behavioural reference, written from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refA = 0; refB = 0;
    end else if (!irqEnable) begin
      refA = 0; refB = 0;
    end else begin
      if (!bCeN && !bWeN && bAddr == BOX_A) refA = 1;
      else if (!aCeN && !aOeN && aAddr == BOX_A) refA = 0;
      if (!aCeN && !aWeN && aAddr == BOX_B) refB = 1;
      else if (!bCeN && !bOeN && bAddr == BOX_B) refB = 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock, then compare with the model away from the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R2/R3/R10 model aIrqN", aIrqN, logic'(refA == 0));
    check("R4/R5/R10 model bIrqN", bIrqN, logic'(refB == 0));
  endtask

  task automatic idle();
    aCeN = 1; aOeN = 1; aWeN = 1; aAddr = '0;
    bCeN = 1; bOeN = 1; bWeN = 1; bAddr = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset aIrqN", aIrqN, 1'b1);
    check("R1 reset bIrqN", bIrqN, 1'b1);
    rstN = 1;
    step();

    // R2: B writes A's mailbox
    bCeN = 0; bWeN = 0; bAddr = BOX_A; step();
    check("R2 aIrqN set", aIrqN, 1'b0);
    check("R2 bIrqN unaffected", bIrqN, 1'b1);

    // R8/R10: other addresses, B reading A's box, A deselected at its box
    idle(); aCeN = 0; aWeN = 0; aAddr = 13'h0123;
    bCeN = 0; bOeN = 0; bAddr = BOX_A; step();
    check("R8 unrelated access keeps aIrqN", aIrqN, 1'b0);
    idle(); aCeN = 1; aOeN = 0; aAddr = BOX_A; step();
    check("R8 ce high no clear", aIrqN, 1'b0);
    idle(); repeat (5) step();
    check("R10 hold aIrqN", aIrqN, 1'b0);

    // R3: clear with write strobe low
    aCeN = 0; aOeN = 0; aWeN = 0; aAddr = BOX_A; step();
    check("R3 clear we low", aIrqN, 1'b1);
    idle(); bCeN = 0; bWeN = 0; bAddr = BOX_A; step();
    idle(); aCeN = 0; aOeN = 0; aAddr = BOX_A; step();
    check("R3 clear we high", aIrqN, 1'b1);

    // R4 and R7
    idle(); aCeN = 0; aWeN = 0; aAddr = BOX_B; step();
    check("R4 bIrqN set", bIrqN, 1'b0);
    check("R4 aIrqN unaffected", aIrqN, 1'b1);
    idle(); bCeN = 0; bWeN = 0; bAddr = BOX_B; step();
    check("R7 own write keeps bIrqN", bIrqN, 1'b0);
    idle(); aCeN = 0; aWeN = 0; aAddr = BOX_A; step();
    check("R7 own write keeps aIrqN", aIrqN, 1'b1);

    // R5
    idle(); bCeN = 0; bOeN = 0; bAddr = BOX_B; step();
    check("R5 bIrqN cleared", bIrqN, 1'b1);

    // R6: simultaneous set and clear
    idle(); bCeN = 0; bWeN = 0; bAddr = BOX_A;
    aCeN = 0; aOeN = 0; aAddr = BOX_A; step();
    check("R6 set wins aIrqN", aIrqN, 1'b0);
    idle(); aCeN = 0; aWeN = 0; aAddr = BOX_B;
    bCeN = 0; bOeN = 0; bAddr = BOX_B; step();
    check("R6 set wins bIrqN", bIrqN, 1'b0);

    // R9: disable clears and blocks
    idle(); irqEnable = 0; step();
    check("R9 disable clears aIrqN", aIrqN, 1'b1);
    check("R9 disable clears bIrqN", bIrqN, 1'b1);
    aCeN = 0; aWeN = 0; aAddr = BOX_B;
    bCeN = 0; bWeN = 0; bAddr = BOX_A; step();
    check("R9 no set aIrqN", aIrqN, 1'b1);
    check("R9 no set bIrqN", bIrqN, 1'b1);
    idle(); irqEnable = 1; step();
    check("R9 re-enable aIrqN", aIrqN, 1'b1);
    check("R9 re-enable bIrqN", bIrqN, 1'b1);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int pa = $urandom_range(0, 3);
      int pb = $urandom_range(0, 3);
      aCeN = 1'($urandom_range(0, 3) == 0);
      aOeN = 1'($urandom_range(0, 1));
      aWeN = 1'($urandom_range(0, 1));
      aAddr = (pa == 0) ? BOX_A : (pa == 1) ? BOX_B : 13'($urandom);
      bCeN = 1'($urandom_range(0, 3) == 0);
      bOeN = 1'($urandom_range(0, 1));
      bWeN = 1'($urandom_range(0, 1));
      bAddr = (pb == 0) ? BOX_A : (pb == 1) ? BOX_B : 13'($urandom);
      irqEnable = ($urandom_range(0, 40) != 0);
      step();
    end

    idle(); irqEnable = 1;
    step();
    finish_run();
  end
endmodule